// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This control block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps a small record for each instruction: a valid bit, its PC and the first fault cause seen for it. Each stage's fault detector reports faults for the instruction that occupies that stage. The block does not act on a fault when it is detected. It stores the cause with the instruction and acts on it only when that instruction reaches the commit point at the end of the memory stage. Because instructions reach that point one at a time and in program order, traps are raised in program order. This holds even when a younger instruction detected its own fault earlier in time.

When a faulting instruction commits, the block does three things. It asserts `flush` for that cycle, which empties the fetch, decode, execute and memory slots and drops any fetch arriving in that cycle. It withholds the memory write and the register write of the faulting instruction. It then raises `trap` for one cycle, together with the cause code and the faulting PC. A global `stall` freezes every slot together with its recorded cause.

The control is a two-state machine. RUN is the normal state. The transition *take* (RUN to TRAP) fires when a faulting instruction commits. TRAP drives the trap pulse. The transition *retire* (TRAP to RUN) always fires one cycle later. RUN stays in RUN while no fault commits.

Top module: `exc_order_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `trap`, `flush`, `mem_wr_en` and `wb_wr_en` are low and all slots are empty.
- R2: An instruction with no fault is fetched when `if_valid` is high at a non-stalled edge. It occupies the memory stage in the fourth cycle after that edge. In that cycle `mem_wr_en` is high, and in the next cycle `wb_wr_en` is high. It never causes a trap.
- R3: Cause codes are: 0 none, 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 arithmetic, 6 data page fault, 7 data misaligned, 8 data protection. `f_flt` and `m_flt` use bit 0 for page fault, bit 1 for misaligned and bit 2 for protection. When several of these bits are set, the lowest set bit wins.
- R4: Once a cause is recorded for an instruction, faults flagged for it in later stages do not replace that cause.
- R5: Traps appear in program order. An older instruction that faults in a later stage traps first. A younger instruction that faulted earlier in time is flushed and never traps.
- R6: `flush` is high exactly in a non-stalled cycle in which a valid memory-stage instruction has a recorded or current cause. That instruction gets no `mem_wr_en` and no `wb_wr_en`.
- R7: After `flush`, the fetch, decode, execute and memory slots are empty, and a fetch offered in the flush cycle is dropped. None of these instructions writes or traps.
- R8: `trap` is high for exactly the one cycle after `flush`. `trap_cause` and `trap_pc` give the faulting instruction's cause and PC, and they hold their values until the next trap.
- R9: While `stall` is high, no slot advances, no instruction is fetched, no fault commits and `wb_wr_en` is low. A clean instruction held in the memory stage writes back exactly once after the stall ends.
- R10: Fault flags for a stage that holds no instruction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze the whole pipeline this cycle |
| if_valid | input | 1 | A new instruction enters fetch at this edge |
| if_pc | input | PC_W | PC of the entering instruction |
| f_flt | input | 3 | Fetch-stage faults (bit0 page, bit1 misaligned, bit2 protection) |
| d_flt | input | 1 | Decode-stage illegal opcode |
| x_flt | input | 1 | Execute-stage arithmetic fault |
| m_flt | input | 3 | Memory-stage faults (bit0 page, bit1 misaligned, bit2 protection) |
| flush | output | 1 | Squash all younger instructions this cycle |
| mem_wr_en | output | 1 | Memory-stage instruction may write memory this cycle |
| wb_wr_en | output | 1 | Write-back instruction may write the register file |
| trap | output | 1 | One-cycle trap request |
| trap_cause | output | 4 | Cause code of the last trap |
| trap_pc | output | PC_W | PC of the last faulting instruction |

## Verification
The bench builds the block with `PC_W = 16`. That width is enough to keep distinct PCs for every scenario while keeping the values in the failure messages short. It also shows that the PC path follows the parameter rather than a fixed 32 bits. The default depth of four tracked slots plus write-back stays fixed. This lets directed sequences place a fault in each stage and a younger, earlier-detected fault behind it. It also makes it possible to stall with a faulting or clean instruction held at the commit point.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;

    localparam int CAUSE_W = 4;
    localparam int NSLOT   = 4;   // fetch, decode, execute, memory

    localparam logic [CAUSE_W-1:0] C_NONE    = 4'd0;
    localparam logic [CAUSE_W-1:0] C_I_PAGE  = 4'd1;
    localparam logic [CAUSE_W-1:0] C_I_ALIGN = 4'd2;
    localparam logic [CAUSE_W-1:0] C_I_PROT  = 4'd3;
    localparam logic [CAUSE_W-1:0] C_ILLEGAL = 4'd4;
    localparam logic [CAUSE_W-1:0] C_ARITH   = 4'd5;
    localparam logic [CAUSE_W-1:0] C_D_PAGE  = 4'd6;
    localparam logic [CAUSE_W-1:0] C_D_ALIGN = 4'd7;
    localparam logic [CAUSE_W-1:0] C_D_PROT  = 4'd8;

    typedef enum logic {
        ST_RUN,
        ST_TRAP
    } trk_state_e;

    // bit0 page fault, bit1 misaligned, bit2 protection; lowest bit wins (R3)
    function automatic logic [CAUSE_W-1:0] enc_access(input logic [2:0] f,
                                                      input logic data_side);
        logic [CAUSE_W-1:0] base;
        base = data_side ? C_D_PAGE : C_I_PAGE;
        if (f[0])      return base;
        else if (f[1]) return base + 4'd1;
        else if (f[2]) return base + 4'd2;
        else           return C_NONE;
    endfunction

endpackage

// File: rtl/exc_slot.sv
module exc_slot #(
    parameter int PC_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                adv,
    input  logic                                kill,
    input  logic                                in_valid,
    input  logic [PC_W-1:0]                     in_pc,
    input  logic [exc_trk_pkg::CAUSE_W-1:0]     in_cause,
    output logic                                valid,
    output logic [PC_W-1:0]                     pc,
    output logic [exc_trk_pkg::CAUSE_W-1:0]     cause
);
    import exc_trk_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            valid <= 1'b0;
            pc    <= '0;
            cause <= C_NONE;
        end else if (adv) begin
            valid <= in_valid;
            pc    <= in_pc;
            cause <= in_valid ? in_cause : C_NONE;
        end
    end

    // empty slot never carries a cause (R10)
    p_empty_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> cause == C_NONE);

endmodule

// File: rtl/exc_commit_fsm.sv
module exc_commit_fsm #(
    parameter int PC_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                take,
    input  logic [exc_trk_pkg::CAUSE_W-1:0]     take_cause,
    input  logic [PC_W-1:0]                     take_pc,
    output logic                                trap,
    output logic [exc_trk_pkg::CAUSE_W-1:0]     trap_cause,
    output logic [PC_W-1:0]                     trap_pc
);
    import exc_trk_pkg::*;

    trk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (take) state_d = ST_TRAP;   // take
            ST_TRAP: state_d = ST_RUN;              // retire
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_cause <= C_NONE;
            trap_pc    <= '0;
        end else if (take) begin
            trap_cause <= take_cause;
            trap_pc    <= take_pc;
        end
    end

    always_comb begin
        trap = (state_q == ST_TRAP);
    end

    p_trap_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);
    p_trap_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> trap && trap_cause == $past(take_cause));
    p_no_take_in_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !take);

endmodule

// File: rtl/exc_order_tracker.sv
module exc_order_tracker #(
    parameter int PC_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                stall,
    input  logic                                if_valid,
    input  logic [PC_W-1:0]                     if_pc,
    input  logic [2:0]                          f_flt,
    input  logic                                d_flt,
    input  logic                                x_flt,
    input  logic [2:0]                          m_flt,
    output logic                                flush,
    output logic                                mem_wr_en,
    output logic                                wb_wr_en,
    output logic                                trap,
    output logic [exc_trk_pkg::CAUSE_W-1:0]     trap_cause,
    output logic [PC_W-1:0]                     trap_pc
);
    import exc_trk_pkg::*;

    localparam int MEM_IDX = NSLOT - 1;

    logic                 v_q   [NSLOT];
    logic [PC_W-1:0]      pc_q  [NSLOT];
    logic [CAUSE_W-1:0]   cs_q  [NSLOT];
    logic [CAUSE_W-1:0]   det   [NSLOT];   // cause detected this cycle per slot

    assign det[0] = enc_access(f_flt, 1'b0);
    assign det[1] = d_flt ? C_ILLEGAL : C_NONE;
    assign det[2] = x_flt ? C_ARITH : C_NONE;
    assign det[3] = enc_access(m_flt, 1'b1);

    logic adv;
    assign adv = !stall;

    genvar k;
    generate
        for (k = 0; k < NSLOT; k++) begin : g_slot
            logic                 nv;
            logic [PC_W-1:0]      npc;
            logic [CAUSE_W-1:0]   ncs;
            if (k == 0) begin : g_entry
                assign nv  = if_valid;
                assign npc = if_pc;
                assign ncs = C_NONE;
            end else begin : g_follow
                // first recorded cause is kept (R4); empty slot flags ignored (R10)
                assign nv  = v_q[k-1];
                assign npc = pc_q[k-1];
                assign ncs = (cs_q[k-1] != C_NONE) ? cs_q[k-1]
                           : (v_q[k-1] ? det[k-1] : C_NONE);
            end
            exc_slot #(.PC_W(PC_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv      (adv),
                .kill     (flush),
                .in_valid (nv),
                .in_pc    (npc),
                .in_cause (ncs),
                .valid    (v_q[k]),
                .pc       (pc_q[k]),
                .cause    (cs_q[k])
            );
        end
    endgenerate

    // commit point at the end of the memory stage
    logic [CAUSE_W-1:0] fin_cause;
    logic               mem_clean;
    assign fin_cause = (cs_q[MEM_IDX] != C_NONE) ? cs_q[MEM_IDX] : det[MEM_IDX];
    assign mem_clean = v_q[MEM_IDX] && (fin_cause == C_NONE);
    assign flush     = v_q[MEM_IDX] && adv && (fin_cause != C_NONE);
    assign mem_wr_en = mem_clean && adv;

    always_ff @(posedge clk) begin
        if (!rst_n) wb_wr_en <= 1'b0;
        else        wb_wr_en <= mem_clean && adv;   // bubble on stall (R9)
    end

    exc_commit_fsm #(.PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (flush),
        .take_cause (fin_cause),
        .take_pc    (pc_q[MEM_IDX]),
        .trap       (trap),
        .trap_cause (trap_cause),
        .trap_pc    (trap_pc)
    );

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(v_q[0] || v_q[1] || v_q[2] || v_q[3]));
    p_fault_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !wb_wr_en);
    p_stall_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(v_q[MEM_IDX]) && $stable(cs_q[MEM_IDX])
                  && $stable(pc_q[MEM_IDX]) && !wb_wr_en);
    p_cause_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !flush && v_q[2] && cs_q[2] != C_NONE) |=> cs_q[3] == $past(cs_q[2]));
    p_store_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && mem_wr_en));

endmodule

// File: tb/exc_order_tracker_test.sv
module exc_order_tracker_test;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          if_valid = 1'b0;
    logic [PW-1:0] if_pc = '0;
    logic [2:0]    f_flt = '0;
    logic          d_flt = 1'b0;
    logic          x_flt = 1'b0;
    logic [2:0]    m_flt = '0;
    logic          flush, mem_wr_en, wb_wr_en, trap;
    logic [3:0]    trap_cause;
    logic [PW-1:0] trap_pc;

    exc_order_tracker #(.PC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .if_valid(if_valid), .if_pc(if_pc),
        .f_flt(f_flt), .d_flt(d_flt), .x_flt(x_flt), .m_flt(m_flt),
        .flush(flush), .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en),
        .trap(trap), .trap_cause(trap_cause), .trap_pc(trap_pc)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int n_trap = 0;
    int n_wb = 0;
    logic s_flush, s_mwr;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // called at a falling edge; samples comb outputs mid-cycle, registered ones after the edge
    task automatic step(input logic fv, input logic [PW-1:0] fpc, input logic [2:0] ff,
                        input logic df, input logic xf, input logic [2:0] mf,
                        input logic st);
        if_valid = fv; if_pc = fpc; f_flt = ff; d_flt = df; x_flt = xf;
        m_flt = mf; stall = st;
        #2;
        s_flush = flush;
        s_mwr   = mem_wr_en;
        @(negedge clk);
        if (trap)     n_trap++;
        if (wb_wr_en) n_wb++;
    endtask

    task automatic idle();
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    endtask

    // one instruction with flags in each stage, expected cause at commit
    task automatic run_one(input logic [PW-1:0] pc, input logic [2:0] ff, input logic df,
                           input logic xf, input logic [2:0] mf, input int exp,
                           input string tag);
        step(1'b1, pc, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b0, '0, ff, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b0, '0, 3'b000, df, 1'b0, 3'b000, 1'b0);
        step(1'b0, '0, 3'b000, 1'b0, xf, 3'b000, 1'b0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, mf, 1'b0);
        chk(s_flush == 1'b1, {tag, " R6 flush at commit"}, int'(s_flush), 1);
        chk(s_mwr == 1'b0, {tag, " R6 store blocked"}, int'(s_mwr), 0);
        chk(trap == 1'b1, {tag, " R8 trap raised"}, int'(trap), 1);
        chk(trap_cause == 4'(exp), {tag, " R3 cause"}, int'(trap_cause), exp);
        chk(trap_pc == pc, {tag, " R8 pc"}, int'(trap_pc), int'(pc));
        idle();
        chk(trap == 1'b0, {tag, " R8 pulse ends"}, int'(trap), 0);
        chk(trap_cause == 4'(exp), {tag, " R8 cause held"}, int'(trap_cause), exp);
    endtask

    task automatic t_reset();
        chk(!trap && !flush && !mem_wr_en && !wb_wr_en, "R1 outputs idle after reset",
            int'({trap, flush, mem_wr_en, wb_wr_en}), 0);
    endtask

    task automatic t_clean_stream();
        int wb0 = n_wb, tr0 = n_trap;
        step(1'b1, 16'h0100, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b1, 16'h0104, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b1, 16'h0108, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        idle();
        chk(n_wb == wb0, "R2 no write before memory stage", n_wb - wb0, 0);
        idle();
        chk(s_mwr == 1'b1, "R2 store enable for first instruction", int'(s_mwr), 1);
        chk(wb_wr_en == 1'b1, "R2 write-back follows", int'(wb_wr_en), 1);
        for (int i = 0; i < 4; i++) idle();
        chk(n_wb - wb0 == 3, "R2 three write-backs", n_wb - wb0, 3);
        chk(n_trap == tr0, "R2 no trap on clean stream", n_trap - tr0, 0);
    endtask

    task automatic t_order();
        int wb0, tr0;
        step(1'b1, 16'h0200, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0); // A fetched
        step(1'b1, 16'h0204, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0); // B fetched
        step(1'b0, '0, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0);        // B fetch page fault
        step(1'b0, '0, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0);        // A arithmetic
        wb0 = n_wb; tr0 = n_trap;
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);        // A commits
        chk(s_flush == 1'b1, "R5 older fault flushes", int'(s_flush), 1);
        chk(trap_cause == 4'd5, "R5 older cause first", int'(trap_cause), 5);
        chk(trap_pc == 16'h0204 - 16'h4, "R5 older pc first", int'(trap_pc), 'h200);
        for (int i = 0; i < 6; i++) idle();
        chk(n_trap - tr0 == 1, "R5 younger fault never traps", n_trap - tr0, 1);
        chk(n_wb == wb0, "R5 no write-back from either", n_wb - wb0, 0);
    endtask

    task automatic t_flush_kill();
        int wb0, tr0;
        step(1'b1, 16'h0300, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b1, 16'h0304, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b1, 16'h0308, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        step(1'b1, 16'h030c, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        wb0 = n_wb; tr0 = n_trap;
        step(1'b1, 16'h0310, 3'b000, 1'b0, 1'b0, 3'b010, 1'b0); // oldest misaligned data
        chk(s_flush == 1'b1, "R7 flush asserted", int'(s_flush), 1);
        chk(trap_cause == 4'd7, "R3 data misaligned code", int'(trap_cause), 7);
        // all slots should be empty: flags here must be ignored
        for (int i = 0; i < 6; i++) step(1'b0, '0, 3'b111, 1'b1, 1'b1, 3'b111, 1'b0);
        chk(n_trap - tr0 == 1, "R10 flags on empty stages ignored", n_trap - tr0, 1);
        chk(n_wb == wb0, "R7 younger instructions squashed", n_wb - wb0, 0);
        wb0 = n_wb; tr0 = n_trap;
        step(1'b1, 16'h0400, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        for (int i = 0; i < 5; i++) idle();
        chk(n_wb - wb0 == 1 && n_trap == tr0, "R7 fetch after trap runs clean",
            n_wb - wb0, 1);
    endtask

    task automatic t_stall();
        int wb0, tr0;
        step(1'b1, 16'h0500, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        idle(); idle(); idle();
        tr0 = n_trap;
        step(1'b1, 16'h0a00, 3'b000, 1'b0, 1'b0, 3'b001, 1'b1);  // stalled commit, fetch offered
        chk(s_flush == 1'b0, "R9 no commit while stalled", int'(s_flush), 0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b001, 1'b1);
        chk(n_trap == tr0, "R9 no trap while stalled", n_trap - tr0, 0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b001, 1'b0);
        chk(s_flush == 1'b1 && trap_cause == 4'd6 && trap_pc == 16'h0500,
            "R9 fault taken after stall", int'(trap_cause), 6);
        // clean instruction held in memory stage
        wb0 = n_wb;
        step(1'b1, 16'h0600, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
        idle(); idle(); idle();
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
        chk(s_mwr == 1'b0 && wb_wr_en == 1'b0, "R9 no writes while stalled",
            int'({s_mwr, wb_wr_en}), 0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
        idle();
        chk(s_mwr == 1'b1, "R9 store after stall", int'(s_mwr), 1);
        for (int i = 0; i < 4; i++) idle();
        chk(n_wb - wb0 == 1, "R9 single write-back", n_wb - wb0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_stream();
        t_order();
        run_one(16'h0700, 3'b000, 1'b1, 1'b1, 3'b001, 4, "R4 sticky decode");
        run_one(16'h0710, 3'b110, 1'b0, 1'b1, 3'b000, 2, "R3 fetch misaligned");
        run_one(16'h0720, 3'b100, 1'b0, 1'b0, 3'b000, 3, "R3 fetch protection");
        run_one(16'h0730, 3'b111, 1'b0, 1'b0, 3'b000, 1, "R3 fetch page");
        run_one(16'h0740, 3'b000, 1'b0, 1'b0, 3'b100, 8, "R3 data protection");
        run_one(16'h0750, 3'b000, 1'b0, 1'b0, 3'b011, 6, "R3 data page");
        t_flush_kill();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule